// File: doc/BRIEF.md
# Pseudo-Random Test Word Injector

This block sits in front of a demultiplexer datapath and can replace the live input word with a self-generated 10-bit test word. One word is produced for each input clock. A divide-by-eight slot counter marks the frame that the downstream demultiplexer uses. Slot 0 feeds output port A. Test mode starts and stops only on a frame boundary. The first test word of a run therefore always lands in slot 0, and the sequence restarts from a fixed seed on every entry.

The nine low bits of the test word come from a shift register with feedback taps at stages 9 and 5. A correction term adds the all-zero state, so every 9-bit value appears exactly once in 512 steps. The top bit is a parity of two of those bits. A clock-type input selects the stepping rate:
- In full-rate mode the sequence steps on every clock, so each port gets a different word.
- In half-rate mode it steps on every second clock, so adjacent slot pairs share a word.

A checker downstream can follow the run through three outputs: a start pulse, the code stream and a valid flag.

Top module: `tpg_inject`

## Requirements
- R1: `slot_a` is high in the first clock cycle after reset is released and then in every eighth cycle. Those cycles are slot 0 of the frame. The frame's last slot is slot 7.
- R2: While the asynchronous reset `rst_a` is high, `chk_valid` and `chk_start` are 0 and `dout` equals `din`. The generator state is held at the seed, 9'h155.
- R3: Test mode is entered only from a cycle in slot 7 that samples `test_en` high while test mode is off. The following cycle is slot 0; in it `chk_valid` becomes 1 and `chk_start` is 1 for exactly that one cycle. A `test_en` pulse that is high only in slots 0 to 6 has no effect.
- R4: The generator state s[8:0] steps to {s[7:0], s[8]^s[4]^(s[7:0]==0)}. The word is `chk_code` = {s[0]^s[4], s[8:0]}.
- R5: With `full_rate`=1 the state steps on every clock while test mode is on. The 512 words after a start are all distinct, and word 512 equals word 0.
- R6: Over one 512-word period, bits 8 to 1 of `chk_code` take all 256 values.
- R7: With `full_rate`=0 the state steps only at the end of odd slots. The words in slots 2k and 2k+1 are therefore equal, and the sequence repeats after 1024 clocks.
- R8: While `chk_valid` is 1, `dout` equals `chk_code` and `din` has no effect on it.
- R9: Test mode is left only from a cycle in slot 7 that samples `test_en` low. From the next cycle onward, `chk_valid` is 0 and `dout` equals `din`.
- R10: Every entry into test mode restarts the sequence. The first word is the seed word 10'h155, which has top bit 1^1=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Demultiplexer input clock |
| rst_a | input | 1 | Asynchronous master reset, active high |
| test_en | input | 1 | Test command; sampled at frame end |
| full_rate | input | 1 | 1: step every clock; 0: step every second clock |
| din | input | 10 | Live input data word |
| dout | output | 10 | Word passed to the demultiplexer |
| slot_a | output | 1 | High in slot 0 (port A) of the frame |
| chk_start | output | 1 | One-cycle pulse on the first test word |
| chk_code | output | 10 | Current generator word |
| chk_valid | output | 1 | High while test words are injected |

## Verification
The assertions assume that `full_rate` is held steady for the whole of a test run. If it changed mid-run, the hold and stepping relations would mix the two rates. The random stimulus therefore changes `full_rate` only while test mode is off and `test_en` is low. It toggles `test_en` rarely and drives `din` with fresh random values on every cycle, so it reaches entry and exit at slot 7 as well as ignored mid-frame pulses. Reset is raised away from any clock edge, which tests the asynchronous path without racing the counter.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic {
        RATE_HALF = 1'b0,
        RATE_FULL = 1'b1
    } rate_e;

    typedef struct packed {
        logic active;
        logic start;
    } mode_t;

endpackage

// File: rtl/tpg_frame_ctr.sv
module tpg_frame_ctr #(
    parameter int FRAME = 8,
    localparam int SW = (FRAME > 1) ? $clog2(FRAME) : 1
) (
    input  logic          clk,
    input  logic          rst_a,
    output logic [SW-1:0] slot_o,
    output logic          first_o,
    output logic          last_o
);
    typedef struct packed {
        logic [SW-1:0] slot;
    } fc_t;

    fc_t fc_d, fc_q;

    always_comb begin
        fc_d = fc_q;
        if (fc_q.slot == SW'(FRAME - 1))
            fc_d.slot = '0;
        else
            fc_d.slot = fc_q.slot + SW'(1);
    end

    always_ff @(posedge clk or posedge rst_a) begin
        if (rst_a) fc_q <= '0;
        else       fc_q <= fc_d;
    end

    assign slot_o  = fc_q.slot;
    assign first_o = (fc_q.slot == '0);
    assign last_o  = (fc_q.slot == SW'(FRAME - 1));

    AST_FIRST_NOT_REPEATED: assert property (@(posedge clk) disable iff (rst_a)
        first_o |=> !first_o); // R1
endmodule

// File: rtl/tpg_seq_core.sv
module tpg_seq_core #(
    parameter int           STATE_W = 9,
    parameter int           TAP     = 5,
    parameter logic [8:0]   SEED    = 9'h155,
    localparam int          CODE_W  = STATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_a,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic [STATE_W-1:0] st;
    } sq_t;

    sq_t sq_d, sq_q;
    logic fb;

    always_comb begin
        sq_d = sq_q;
        fb   = sq_q.st[STATE_W-1] ^ sq_q.st[TAP-1]
             ^ (sq_q.st[STATE_W-2:0] == '0);
        if (load_i)
            sq_d.st = STATE_W'(SEED);
        else if (adv_i)
            sq_d.st = {sq_q.st[STATE_W-2:0], fb};
    end

    always_ff @(posedge clk or posedge rst_a) begin
        if (rst_a) sq_q.st <= STATE_W'(SEED);
        else       sq_q    <= sq_d;
    end

    assign code_o = {sq_q.st[0] ^ sq_q.st[TAP-1], sq_q.st};

    AST_ZERO_EXIT: assert property (@(posedge clk) disable iff (rst_a)
        (code_o[STATE_W-1:0] == '0 && adv_i && !load_i)
        |=> code_o[STATE_W-1:0] == STATE_W'(1)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst_a)
        (!adv_i && !load_i) |=> $stable(code_o)); // R7
    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst_a)
        load_i |=> code_o[STATE_W-1:0] == STATE_W'(SEED)); // R10
endmodule

// File: rtl/tpg_inject.sv
module tpg_inject
    import tpg_pkg::*;
#(
    parameter int         STATE_W = 9,
    parameter int         TAP     = 5,
    parameter int         FRAME   = 8,
    parameter logic [8:0] SEED    = 9'h155,
    localparam int        CODE_W  = STATE_W + 1,
    localparam int        SW      = (FRAME > 1) ? $clog2(FRAME) : 1
) (
    input  logic              clk,
    input  logic              rst_a,
    input  logic              test_en,
    input  logic              full_rate,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] dout,
    output logic              slot_a,
    output logic              chk_start,
    output logic [CODE_W-1:0] chk_code,
    output logic              chk_valid
);
    localparam logic [CODE_W-1:0] SEED_WORD =
        {SEED[0] ^ SEED[TAP-1], STATE_W'(SEED)};

    mode_t         mode_d, mode_q;
    logic [SW-1:0] slot;
    logic          frame_first, frame_last;
    logic          load, adv;
    rate_e         rate;

    tpg_frame_ctr #(.FRAME(FRAME)) u_frame (
        .clk     (clk),
        .rst_a   (rst_a),
        .slot_o  (slot),
        .first_o (frame_first),
        .last_o  (frame_last)
    );

    assign rate = full_rate ? RATE_FULL : RATE_HALF;

    always_comb begin
        mode_d       = mode_q;
        mode_d.start = 1'b0;
        load         = 1'b0;
        if (frame_last) begin
            if (test_en && !mode_q.active) begin
                mode_d.active = 1'b1;
                mode_d.start  = 1'b1;
                load          = 1'b1;
            end else if (!test_en) begin
                mode_d.active = 1'b0;
            end
        end
        adv = mode_q.active && ((rate == RATE_FULL) || slot[0]);
    end

    always_ff @(posedge clk or posedge rst_a) begin
        if (rst_a) mode_q <= '0;
        else       mode_q <= mode_d;
    end

    tpg_seq_core #(.STATE_W(STATE_W), .TAP(TAP), .SEED(SEED)) u_seq (
        .clk    (clk),
        .rst_a  (rst_a),
        .load_i (load),
        .adv_i  (adv),
        .code_o (chk_code)
    );

    assign dout      = mode_q.active ? chk_code : din;
    assign slot_a    = frame_first;
    assign chk_start = mode_q.start;
    assign chk_valid = mode_q.active;

    AST_START_ON_A: assert property (@(posedge clk) disable iff (rst_a)
        chk_start |-> slot_a); // R3
    AST_START_VALID: assert property (@(posedge clk) disable iff (rst_a)
        chk_start |-> chk_valid); // R3
    AST_MODE_ON_FRAME: assert property (@(posedge clk) disable iff (rst_a)
        ($rose(chk_valid) || $fell(chk_valid)) |-> slot_a); // R9
    AST_START_WORD: assert property (@(posedge clk) disable iff (rst_a)
        chk_start |-> chk_code == SEED_WORD); // R10
endmodule

// File: tb/sim_tpg_inject.sv
`timescale 1ns/1ps
module sim_tpg_inject;
    localparam logic [8:0] SEED = 9'h155;

    logic       clk = 1'b0;
    logic       rst_a = 1'b1;
    logic       test_en = 1'b0;
    logic       full_rate = 1'b1;
    logic [9:0] din = '0;
    logic [9:0] dout, chk_code;
    logic       slot_a, chk_start, chk_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [2:0] m_slot;
    logic       m_act, m_start;
    logic [8:0] m_st;

    always #2 clk = ~clk;

    tpg_inject u0 (
        .clk(clk), .rst_a(rst_a), .test_en(test_en), .full_rate(full_rate),
        .din(din), .dout(dout), .slot_a(slot_a), .chk_start(chk_start),
        .chk_code(chk_code), .chk_valid(chk_valid)
    );

    function automatic logic [8:0] nxt(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4] ^ (s[7:0] == 8'h00)};
    endfunction

    function automatic logic [9:0] word(input logic [8:0] s);
        return {s[0] ^ s[4], s};
    endfunction

    always @(posedge clk or posedge rst_a) begin
        if (rst_a) begin
            m_slot <= 3'd0; m_act <= 1'b0; m_start <= 1'b0; m_st <= SEED;
        end else begin
            m_slot  <= m_slot + 3'd1;
            m_start <= (m_slot == 3'd7) && test_en && !m_act;
            if (m_slot == 3'd7 && test_en != m_act) begin
                m_act <= test_en;
                if (test_en) m_st <= SEED;
            end else if (m_act && (full_rate || m_slot[0])) begin
                m_st <= nxt(m_st);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(slot_a == (m_slot == 3'd0), "R1 slot_a", slot_a, m_slot == 3'd0);
        check(chk_valid == m_act, "R3/R9 valid", chk_valid, m_act);
        check(chk_start == m_start, "R3 start", chk_start, m_start);
        if (m_act) begin
            check(chk_code == word(m_st), "R4 code", chk_code, word(m_st));
            check(dout == word(m_st), "R8 inject", dout, word(m_st));
        end else begin
            check(dout == din, "R9 pass", dout, din);
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        din = 10'($urandom);
    endtask

    task automatic wait_start();
        for (int i = 0; i < 40; i++) begin
            step();
            if (chk_start) return;
        end
        check(0, "R3 no start", 0, 1);
    endtask

    task automatic wait_idle();
        test_en = 1'b0;
        for (int i = 0; i < 40 && m_act; i++) step();
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit [255:0] mid_seen;
        bit [511:0] st_seen;
        logic [9:0] first_w, w;
        int distinct;
        void'($urandom(32'h1234_5678));

        // R2: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            din = 10'($urandom);
            #0.5;
            check(!chk_valid && !chk_start, "R2 flags", {chk_valid, chk_start}, 0);
            check(dout == din, "R2 pass", dout, din);
        end
        @(negedge clk);
        rst_a = 1'b0;
        din = 10'($urandom);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            step();
            if ($urandom_range(0, 39) == 0) test_en = ~test_en;
            if (!test_en && !m_act && $urandom_range(0, 3) == 0)
                full_rate = $urandom_range(0, 1);
        end

        // R5/R6: full-rate period and coverage
        wait_idle();
        full_rate = 1'b1;
        test_en = 1'b1;
        wait_start();
        check(chk_code == word(SEED), "R10 first word", chk_code, word(SEED));
        first_w = chk_code;
        mid_seen = '0; st_seen = '0; distinct = 0;
        for (int k = 0; k < 512; k++) begin
            if (k > 0) step();
            w = chk_code;
            if (!st_seen[w[8:0]]) distinct++;
            st_seen[w[8:0]] = 1'b1;
            mid_seen[w[8:1]] = 1'b1;
            check(w[9] == (w[0] ^ w[4]), "R4 top bit", w[9], w[0] ^ w[4]);
        end
        check(distinct == 512, "R5 distinct", distinct, 512);
        check(mid_seen == '1, "R6 coverage", $countones(mid_seen), 256);
        step();
        check(chk_code == first_w, "R5 period", chk_code, first_w);

        // R7: half-rate holding and period
        wait_idle();
        full_rate = 1'b0;
        test_en = 1'b1;
        wait_start();
        first_w = chk_code;
        for (int k = 0; k < 16; k++) begin
            w = chk_code;
            step();
            if (k % 2 == 0)
                check(chk_code == w, "R7 pair hold", chk_code, w);
        end
        for (int k = 16; k < 1024; k++) step();
        check(chk_code == first_w, "R7 period", chk_code, first_w);

        // R3: mid-frame pulse ignored
        wait_idle();
        while (m_slot != 3'd2) step();
        test_en = 1'b1;
        step(); step(); step();
        test_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            step();
            check(!chk_valid, "R3 pulse ignored", chk_valid, 0);
        end

        // R10: restart from seed; R2: async reset mid-run
        full_rate = 1'b1;
        test_en = 1'b1;
        wait_start();
        check(chk_code == word(SEED), "R10 restart", chk_code, word(SEED));
        for (int k = 0; k < 5; k++) step();
        #1 rst_a = 1'b1;
        #0.5;
        check(!chk_valid, "R2 async valid", chk_valid, 0);
        check(dout == din, "R2 async pass", dout, din);
        @(negedge clk);
        rst_a = 1'b0;
        test_en = 1'b0;
        for (int k = 0; k < 20; k++) step();

        finish_run();
    end
endmodule